// File: doc/BRIEF.md
# Multiple-polynomial reseeding pattern generator

This block produces deterministic scan patterns from compact stored words. Each word holds a small feedback-selector field and a seed. For every pattern the generator accepts one word, loads a shift-register generator with the seed, picks the feedback tap mask named by the selector field, and then clocks the generator for exactly one scan-chain length. Each cycle it presents one bit on a serial output, together with an enable that frames the shift window.

A session begins with a `start` pulse. The block then fetches and expands a fixed number of words, one after the other, through a valid/ready handshake. It raises a one-cycle done strobe after each pattern and keeps a running count of the patterns it has completed. When the last pattern of the session is done, it returns to idle. Because the selector can differ from word to word, a seed that cannot be reached with one feedback polynomial can be stored against another polynomial instead. Storage for N patterns is N times the word width.

Top module: `reseed_pattern_gen`

## Requirements
- R1: After a synchronous reset, `word_ready`, `scan_en`, `scan_out` and `pattern_done` are 0 and `pattern_count` is 0.
- R2: A `start` pulse while idle raises `word_ready` in the following cycle and clears `pattern_count`. A `start` during a session has no effect.
- R3: A word is taken in the cycle where `word_valid` and `word_ready` are both 1. Bits [LFSR_W-1:0] are the seed and bits [WORD_W-1:LFSR_W] are the polynomial selector. `word_ready` is 0 from the next cycle until the pattern is done.
- R4: `scan_en` is 1 for exactly CHAIN_LEN consecutive cycles, starting in the cycle after the word is taken.
- R5: With state s loaded from the seed, each shift cycle shows `scan_out` = s[0], and s then becomes {^(s & mask), s[LFSR_W-1:1]}.
- R6: Mask entry i is ((5*i+9) mod 2^LFSR_W) | 1 for i < NUM_POLY (default 12). A selector of NUM_POLY or more uses entry 0.
- R7: `pattern_done` is a one-cycle pulse in the cycle after the last shift cycle.
- R8: `pattern_count` rises by one with each `pattern_done`. After NUM_PAT patterns (default 4) the block goes idle and `word_ready` stays 0.
- R9: An all-zero seed produces 0 on `scan_out` for every shift cycle of that pattern.
- R10: `word_valid` while `word_ready` is 0 is ignored: the current pattern's bit stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a session while idle |
| word_valid | input | 1 | Stored word offered |
| word_ready | output | 1 | Generator can take a word |
| word_data | input | WORD_W | Selector (upper) and seed (lower) |
| scan_en | output | 1 | High during the shift window |
| scan_out | output | 1 | Serial pattern bit |
| pattern_done | output | 1 | One-cycle end-of-pattern strobe |
| pattern_count | output | CNT_W | Patterns completed this session |

## Verification
Two events can coincide while a pattern is shifting: a word can be offered, or a new `start` can arrive. The bench provokes both in the same run. It holds `word_valid` high with random data across a whole shift window and pulses `start` in the middle of it. The pattern passes only if every serial bit still matches the model expanded from the word actually taken, and `pattern_count` at the done strobe shows that the session was not restarted.

// File: rtl/mprg_pkg.sv
package mprg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    // Feedback tap mask for table slot idx; bit 0 always taps the output stage.
    function automatic int tap_entry(input int idx, input int width);
        return ((5 * idx + 9) % (1 << width)) | 1;
    endfunction

endpackage

// File: rtl/mprg_tap_select.sv
module mprg_tap_select #(
    parameter int LFSR_W   = 4,
    parameter int ID_W     = 4,
    parameter int NUM_POLY = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ID_W-1:0]   id_in,
    output logic [LFSR_W-1:0] mask
);
    localparam int SLOTS = 1 << ID_W;

    logic [LFSR_W-1:0] tbl [SLOTS];
    logic [ID_W-1:0]   id_q;

    for (genvar i = 0; i < SLOTS; i++) begin : g_tbl
        if (i < NUM_POLY) begin : g_pop
            assign tbl[i] = LFSR_W'(mprg_pkg::tap_entry(i, LFSR_W));
        end else begin : g_fallback
            assign tbl[i] = LFSR_W'(mprg_pkg::tap_entry(0, LFSR_W));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       id_q <= '0;
        else if (load) id_q <= id_in;
    end

    assign mask = tbl[id_q];

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mask));

endmodule

// File: rtl/mprg_lfsr.sv
module mprg_lfsr #(
    parameter int LFSR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [LFSR_W-1:0] seed,
    input  logic [LFSR_W-1:0] mask,
    output logic              bit_out
);
    logic [LFSR_W-1:0] st_q;
    logic              fb;

    assign fb      = ^(st_q & mask);
    assign bit_out = st_q[0];

    always_ff @(posedge clk) begin
        if (rst)        st_q <= '0;
        else if (load)  st_q <= seed;
        else if (shift) st_q <= {fb, st_q[LFSR_W-1:1]};
    end

    // R5
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> st_q[LFSR_W-2:0] == $past(st_q[LFSR_W-1:1]));

    // R9
    zero_lockin_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load && st_q == '0) |=> st_q == '0);

endmodule

// File: rtl/mprg_seq.sv
module mprg_seq #(
    parameter int CHAIN_LEN = 10,
    parameter int NUM_PAT   = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             word_valid,
    output logic             word_ready,
    output logic             load,
    output logic             shift,
    output logic             done,
    output logic [CNT_W-1:0] pat_cnt
);
    import mprg_pkg::*;

    localparam int SH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [SH_W-1:0]  LAST_SH = SH_W'(CHAIN_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_PAT = CNT_W'(NUM_PAT);

    seq_state_e      state_q;
    logic [SH_W-1:0] sh_q;

    assign word_ready = (state_q == ST_FETCH);
    assign load       = word_ready && word_valid;
    assign shift      = (state_q == ST_SHIFT);
    assign done       = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            pat_cnt <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    pat_cnt <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (word_valid) begin
                    sh_q    <= '0;
                    state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    sh_q <= sh_q + 1'b1;
                    if (sh_q == LAST_SH) begin
                        pat_cnt <= pat_cnt + 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= (pat_cnt == LAST_PAT) ? ST_IDLE : ST_FETCH;
            endcase
        end
    end

    // R3
    accept_to_shift_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (shift && !word_ready));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shift) |-> done);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> pat_cnt == $past(pat_cnt) + 1'b1);

endmodule

// File: rtl/reseed_pattern_gen.sv
module reseed_pattern_gen #(
    parameter int LFSR_W    = 4,
    parameter int ID_W      = 4,
    parameter int NUM_POLY  = 12,
    parameter int CHAIN_LEN = 10,
    parameter int NUM_PAT   = 4,
    localparam int WORD_W   = LFSR_W + ID_W,
    localparam int CNT_W    = $clog2(NUM_PAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              scan_en,
    output logic              scan_out,
    output logic              pattern_done,
    output logic [CNT_W-1:0]  pattern_count
);
    logic              load, shift, lfsr_bit;
    logic [LFSR_W-1:0] mask;

    mprg_seq #(
        .CHAIN_LEN (CHAIN_LEN),
        .NUM_PAT   (NUM_PAT),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .load       (load),
        .shift      (shift),
        .done       (pattern_done),
        .pat_cnt    (pattern_count)
    );

    mprg_tap_select #(
        .LFSR_W   (LFSR_W),
        .ID_W     (ID_W),
        .NUM_POLY (NUM_POLY)
    ) u_taps (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .id_in (word_data[WORD_W-1:LFSR_W]),
        .mask  (mask)
    );

    mprg_lfsr #(
        .LFSR_W (LFSR_W)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .shift   (shift),
        .seed    (word_data[LFSR_W-1:0]),
        .mask    (mask),
        .bit_out (lfsr_bit)
    );

    assign scan_en  = shift;
    assign scan_out = shift & lfsr_bit;

    // R4
    no_ready_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> !word_ready);

endmodule

// File: tb/reseed_pattern_gen_bench.sv
module reseed_pattern_gen_bench;
    localparam int K = 4, Q = 4, M = 10, NP = 4, NPOLY = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic word_valid = 1'b0;
    logic [K+Q-1:0] word_data = '0;
    logic word_ready, scan_en, scan_out, pattern_done;
    logic [2:0] pattern_count;

    int n_chk = 0, n_bad = 0, cycles = 0;

    always #4 clk = ~clk;

    reseed_pattern_gen u_reseed_pattern_gen (
        .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
        .word_ready(word_ready), .word_data(word_data), .scan_en(scan_en),
        .scan_out(scan_out), .pattern_done(pattern_done),
        .pattern_count(pattern_count)
    );

    function automatic logic [K-1:0] ref_mask(input int id);
        int j = (id >= NPOLY) ? 0 : id;
        return K'(((5 * j + 9) % 16) | 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Called just after a negedge, block idle.
    task automatic begin_session();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(word_ready == 1'b1, "R2 ready after start", int'(word_ready), 1);
        check(pattern_count == 0, "R8 count cleared", int'(pattern_count), 0);
    endtask

    task automatic run_pattern(input logic [K+Q-1:0] w, input bit noise, input int exp_cnt);
        logic [K-1:0] s, m;
        int guard = 0;
        while (!word_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check(word_ready == 1'b1, "R3 ready before word", int'(word_ready), 1);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = noise;
        if (noise) word_data = 8'($urandom);
        s = w[K-1:0];
        m = ref_mask(int'(w[K+Q-1:K]));
        for (int i = 0; i < M; i++) begin
            check(scan_en == 1'b1, "R4 scan_en window", int'(scan_en), 1);
            check(word_ready == 1'b0, "R3 ready low in shift", int'(word_ready), 0);
            check(scan_out == s[0], noise ? "R10 bit with noise" : "R5 R6 R9 scan bit",
                  int'(scan_out), int'(s[0]));
            s = {^(s & m), s[K-1:1]};
            start = noise && (i == 3);
            @(negedge clk);
        end
        word_valid = 1'b0;
        start = 1'b0;
        check(scan_en == 1'b0, "R4 window end", int'(scan_en), 0);
        check(pattern_done == 1'b1, "R7 done pulse", int'(pattern_done), 1);
        check(int'(pattern_count) == exp_cnt, "R8 count", int'(pattern_count), exp_cnt);
        @(negedge clk);
        check(pattern_done == 1'b0, "R7 done single", int'(pattern_done), 0);
    endtask

    task automatic end_session_check();
        check(word_ready == 1'b0, "R8 idle after session", int'(word_ready), 0);
        repeat (3) @(negedge clk);
        check(word_ready == 1'b0, "R8 stays idle", int'(word_ready), 0);
        check(int'(pattern_count) == NP, "R8 final count", int'(pattern_count), NP);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(word_ready == 1'b0, "R1 ready", int'(word_ready), 0);
        check(scan_en == 1'b0, "R1 scan_en", int'(scan_en), 0);
        check(scan_out == 1'b0, "R1 scan_out", int'(scan_out), 0);
        check(pattern_done == 1'b0, "R1 done", int'(pattern_done), 0);
        check(pattern_count == 0, "R1 count", int'(pattern_count), 0);
        // R10: valid while idle is not taken
        word_valid = 1'b1;
        repeat (2) @(negedge clk);
        check(scan_en == 1'b0, "R10 idle valid ignored", int'(scan_en), 0);
        word_valid = 1'b0;
        @(negedge clk);

        // Directed session: reference polynomial, fallback ID, zero seed, noise
        begin_session();
        run_pattern({4'd0, 4'b0001}, 1'b0, 1);
        run_pattern({4'd13, 4'b1011}, 1'b0, 2);   // R6 fallback to entry 0
        run_pattern({4'd1, 4'b0000}, 1'b0, 3);    // R9 zero seed
        run_pattern({4'd7, 4'b0110}, 1'b1, 4);    // R10 and R2 mid-shift start
        end_session_check();

        // Random sessions
        for (int sess = 0; sess < 6; sess++) begin
            begin_session();
            for (int p = 0; p < NP; p++)
                run_pattern(8'($urandom), 1'($urandom % 2), p + 1);
            end_session_check();
        end
        finish_run();
    end
endmodule